// File: doc/BRIEF.md
# Time-Multiplexed Spiking Neuron Array

This block advances the state of a group of virtual spiking neurons that all share one set of dynamics constants. Each neuron has a membrane value `v` and a recovery value `u`, both held in small per-neuron register files inside the block. One update pass is called a sweep. It solves the quadratic-integrate-and-fire difference equation once for every neuron, using one pipelined fixed-point fused multiply-add unit and a combinational adder.

A sweep has four phases. In each phase the control issues one operation per cycle, for neuron 0 first and then for each neuron in turn. Because of this ordering, a neuron's pipeline result always returns before that neuron's next phase reads it, and the multiply-add unit takes a new operation on every cycle of the sweep. Intermediate results are parked in a per-neuron, per-phase scratch file. A neuron that crosses threshold reports a one-cycle spike together with its index. The end of the sweep is marked by a one-cycle done pulse.

A host pulses the start input, holds the per-neuron input currents steady, and collects spikes until done. A new sweep may be requested in the very cycle that done is shown.

Top module: `spiking_neuron_array`

## Requirements
- R1: After reset every neuron holds v = 0 and u = 0, and both spikeValid and sweepDone are low until a sweep is started.
- R2: A start pulse seen while idle launches a sweep. sweepDone is high for exactly one cycle, 4*NUM+LAT clock edges after the edge that sampled the start. NUM = 2**IDX_W is 16 and the pipeline latency LAT is 4 by default.
- R3: All values are W-bit two's complement with FRAC fraction bits (16 and 8 by default). The multiply-add computes m(x,y,z) = trunc_W((x*y) >>> FRAC) + z, wrapping to W bits. Each neuron's update uses the shared constants quadGain, linGain, bias, recovRate and recovSens: p = m(m(quadGain,v,linGain), v, bias), vN = v + p - u + I, q = m(recovSens, v, -u), uN = m(recovRate, q, u). Every sum wraps to W bits.
- R4: If vN >= thresh (signed compare, equality included), the neuron's v becomes resetV, its u becomes uN + resetStep, and it spikes. Otherwise v becomes vN, u becomes uN, and there is no spike.
- R5: A spike for neuron n is a one-cycle spikeValid with spikeIdx = n, shown 3*NUM+n+LAT+1 edges after the start edge. Within a sweep, spike indices rise strictly.
- R6: A start pulse is ignored from the start edge up to and including the cycle before sweepDone. It does not change the timing or the results of the running sweep, and no further sweep follows it.
- R7: A start pulse in the same cycle as sweepDone is accepted and begins the next sweep straight away.
- R8: Neuron n takes its input current I from curIn[n*W +: W]. The host holds curIn stable for the whole sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSweep | input | 1 | Request for one update pass over all neurons |
| curIn | input | NUM*W | Packed input currents, neuron n at bits n*W +: W |
| quadGain | input | W | Coefficient on v squared |
| linGain | input | W | Coefficient on v |
| bias | input | W | Constant drive term |
| thresh | input | W | Firing threshold on the new v |
| recovRate | input | W | Recovery time-scale constant |
| recovSens | input | W | Recovery sensitivity to v |
| resetV | input | W | Value loaded into v after a spike |
| resetStep | input | W | Increment added to u after a spike |
| spikeValid | output | 1 | One-cycle spike strobe |
| spikeIdx | output | IDX_W | Index of the spiking neuron |
| sweepDone | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Three events can share a cycle. The write-back of the last neuron raises its spike and sweepDone together. A host start may arrive in that same done cycle, or one cycle earlier while the block is still busy. The bench chains sweeps back to back by driving start in the done cycle, and also pulses start in the cycle just before done and in the middle of a sweep. It then compares every spike's cycle and index, and the done timing of the following sweep, against an arithmetic model of the neuron equations. After the last sweep it watches an idle window in which no spike or done may appear.

// File: rtl/neu_pkg.sv
package neu_pkg;
  // log2 of the number of virtual neurons
  parameter int IDX_W = 4;
  localparam int NUM = 2 ** IDX_W;

  typedef enum logic [1:0] {
    PH_QUAD = 2'd0,
    PH_VOLT = 2'd1,
    PH_RECQ = 2'd2,
    PH_RECU = 2'd3
  } phase_t;

  // strobes from control to datapath, one operation per cycle
  typedef struct packed {
    logic              issue;
    phase_t            phase;
    logic [IDX_W-1:0]  idx;
  } issue_t;
endpackage

// File: rtl/neu_fma.sv
module neu_fma #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int LAT  = 4,
  parameter int TAGW = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [TAGW-1:0]     inTag,
  input  logic signed [W-1:0] opX,
  input  logic signed [W-1:0] opY,
  input  logic signed [W-1:0] opZ,
  output logic                outValid,
  output logic [TAGW-1:0]     outTag,
  output logic signed [W-1:0] outRes
);
  localparam int PW = 2 * W;

  // stage 1: operand registers
  logic                s1Valid;
  logic [TAGW-1:0]     s1Tag;
  logic signed [W-1:0] s1X, s1Y, s1Z;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Tag   <= '0;
      s1X     <= '0;
      s1Y     <= '0;
      s1Z     <= '0;
    end else begin
      s1Valid <= inValid;
      s1Tag   <= inTag;
      s1X     <= opX;
      s1Y     <= opY;
      s1Z     <= opZ;
    end
  end

  logic signed [PW-1:0] xExt, yExt, prod, prodSh;
  logic signed [W-1:0]  fused;

  always_comb begin
    xExt   = {{W{s1X[W-1]}}, s1X};
    yExt   = {{W{s1Y[W-1]}}, s1Y};
    prod   = xExt * yExt;
    prodSh = prod >>> FRAC;
    fused  = prodSh[W-1:0] + s1Z;
  end

  // stages 2..LAT: result registers
  logic                vPipe [LAT-1];
  logic [TAGW-1:0]     tPipe [LAT-1];
  logic signed [W-1:0] rPipe [LAT-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe[0] <= 1'b0;
      tPipe[0] <= '0;
      rPipe[0] <= '0;
    end else begin
      vPipe[0] <= s1Valid;
      tPipe[0] <= s1Tag;
      rPipe[0] <= fused;
    end
  end

  for (genvar s = 1; s < LAT - 1; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vPipe[s] <= 1'b0;
        tPipe[s] <= '0;
        rPipe[s] <= '0;
      end else begin
        vPipe[s] <= vPipe[s-1];
        tPipe[s] <= tPipe[s-1];
        rPipe[s] <= rPipe[s-1];
      end
    end
  end

  assign outValid = vPipe[LAT-2];
  assign outTag   = tPipe[LAT-2];
  assign outRes   = rPipe[LAT-2];
endmodule

// File: rtl/neu_ctrl.sv
module neu_ctrl
  import neu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startSweep,
  input  logic   wbLast,
  output issue_t iss,
  output logic   sweepDone
);
  localparam int CNTW = IDX_W + 2;
  localparam logic [CNTW-1:0] LASTOP = CNTW'(4 * NUM - 1);

  logic            busy, issuing;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      issuing   <= 1'b0;
      cnt       <= '0;
      sweepDone <= 1'b0;
    end else begin
      sweepDone <= wbLast;
      if (!busy) begin
        if (startSweep) begin
          busy    <= 1'b1;
          issuing <= 1'b1;
          cnt     <= '0;
        end
      end else begin
        if (issuing) begin
          cnt <= cnt + 1'b1;
          if (cnt == LASTOP) issuing <= 1'b0;
        end
        if (wbLast) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    iss.issue = issuing;
    iss.phase = phase_t'(cnt[CNTW-1 -: 2]);
    iss.idx   = cnt[IDX_W-1:0];
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |=> !sweepDone); // R2

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> !issuing); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (issuing && startSweep && cnt != LASTOP) |=> (issuing && cnt == $past(cnt) + 1'b1)); // R6
endmodule

// File: rtl/neu_datapath.sv
module neu_datapath
  import neu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int LAT  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  issue_t                iss,
  input  logic [NUM*W-1:0]      curIn,
  input  logic signed [W-1:0]   quadGain,
  input  logic signed [W-1:0]   linGain,
  input  logic signed [W-1:0]   bias,
  input  logic signed [W-1:0]   thresh,
  input  logic signed [W-1:0]   recovRate,
  input  logic signed [W-1:0]   recovSens,
  input  logic signed [W-1:0]   resetV,
  input  logic signed [W-1:0]   resetStep,
  output logic                  wbLast,
  output logic                  spikeValid,
  output logic [IDX_W-1:0]      spikeIdx
);
  localparam int TAGW = IDX_W + 2;
  localparam int NSCR = 3;   // slots: 0 quadratic partial, 1 new v, 2 recovery partial

  logic signed [W-1:0] vMem [NUM];
  logic signed [W-1:0] uMem [NUM];
  logic signed [W-1:0] scr  [NUM][NSCR];

  // operand selection at issue
  logic signed [W-1:0] opX, opY, opZ, issV, issU;
  always_comb begin
    issV = vMem[iss.idx];
    issU = uMem[iss.idx];
    unique case (iss.phase)
      PH_QUAD: begin opX = quadGain;          opY = issV;              opZ = linGain; end
      PH_VOLT: begin opX = scr[iss.idx][0];   opY = issV;              opZ = bias;    end
      PH_RECQ: begin opX = recovSens;         opY = issV;              opZ = -issU;   end
      default: begin opX = recovRate;         opY = scr[iss.idx][2];   opZ = issU;    end
    endcase
  end

  logic                wbValid;
  logic [TAGW-1:0]     wbTag;
  logic signed [W-1:0] wbRes;

  neu_fma #(.W(W), .FRAC(FRAC), .LAT(LAT), .TAGW(TAGW)) fma_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (iss.issue),
    .inTag    ({iss.phase, iss.idx}),
    .opX      (opX),
    .opY      (opY),
    .opZ      (opZ),
    .outValid (wbValid),
    .outTag   (wbTag),
    .outRes   (wbRes)
  );

  phase_t             wbPhase;
  logic [IDX_W-1:0]   wbIdx;
  logic signed [W-1:0] wbV, wbU, wbCur, vSum, vCand, uPost;
  logic               fire;

  // combinational adder path for write-back
  always_comb begin
    wbPhase = phase_t'(wbTag[TAGW-1 -: 2]);
    wbIdx   = wbTag[IDX_W-1:0];
    wbV     = vMem[wbIdx];
    wbU     = uMem[wbIdx];
    wbCur   = curIn[int'(wbIdx) * W +: W];
    vSum    = wbV + wbRes - wbU + wbCur;
    vCand   = scr[wbIdx][1];
    fire    = (vCand >= thresh);
    uPost   = fire ? (wbRes + resetStep) : wbRes;
    wbLast  = wbValid && (wbPhase == PH_RECU) && (wbIdx == IDX_W'(NUM - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int n = 0; n < NUM; n++) begin
        vMem[n] <= '0;
        uMem[n] <= '0;
        for (int k = 0; k < NSCR; k++) scr[n][k] <= '0;
      end
      spikeValid <= 1'b0;
      spikeIdx   <= '0;
    end else begin
      spikeValid <= 1'b0;
      if (wbValid) begin
        unique case (wbPhase)
          PH_QUAD: scr[wbIdx][0] <= wbRes;
          PH_VOLT: scr[wbIdx][1] <= vSum;
          PH_RECQ: scr[wbIdx][2] <= wbRes;
          default: begin
            vMem[wbIdx] <= fire ? resetV : vCand;
            uMem[wbIdx] <= uPost;
            spikeValid  <= fire;
            spikeIdx    <= wbIdx;
          end
        endcase
      end
    end
  end

  AST_SPIKE_RESETS_V: assert property (@(posedge clk) disable iff (!rstN)
    spikeValid |-> (vMem[spikeIdx] == $past(resetV))); // R4

  AST_SPIKE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (spikeValid && $past(spikeValid)) |-> (spikeIdx == $past(spikeIdx) + 1'b1)); // R5
endmodule

// File: rtl/spiking_neuron_array.sv
module spiking_neuron_array
  import neu_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int LAT  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startSweep,
  input  logic [NUM*W-1:0]    curIn,
  input  logic signed [W-1:0] quadGain,
  input  logic signed [W-1:0] linGain,
  input  logic signed [W-1:0] bias,
  input  logic signed [W-1:0] thresh,
  input  logic signed [W-1:0] recovRate,
  input  logic signed [W-1:0] recovSens,
  input  logic signed [W-1:0] resetV,
  input  logic signed [W-1:0] resetStep,
  output logic                spikeValid,
  output logic [IDX_W-1:0]    spikeIdx,
  output logic                sweepDone
);
  // a result must be written back before the same neuron's next phase reads it
  initial begin
    if (LAT < 2 || LAT > NUM - 1) $error("LAT out of range");
  end

  issue_t iss;
  logic   wbLast;

  neu_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startSweep (startSweep),
    .wbLast     (wbLast),
    .iss        (iss),
    .sweepDone  (sweepDone)
  );

  neu_datapath #(.W(W), .FRAC(FRAC), .LAT(LAT)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .iss        (iss),
    .curIn      (curIn),
    .quadGain   (quadGain),
    .linGain    (linGain),
    .bias       (bias),
    .thresh     (thresh),
    .recovRate  (recovRate),
    .recovSens  (recovSens),
    .resetV     (resetV),
    .resetStep  (resetStep),
    .wbLast     (wbLast),
    .spikeValid (spikeValid),
    .spikeIdx   (spikeIdx)
  );
endmodule

// File: tb/spiking_neuron_array_tb_top.sv
module spiking_neuron_array_tb_top;
  localparam int W = 16;
  localparam int FRAC = 8;
  localparam int LAT = 4;
  localparam int NUM = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSweep = 1'b0;
  logic [NUM*W-1:0] curIn = '0;
  logic signed [W-1:0] quadGain, linGain, bias, thresh;
  logic signed [W-1:0] recovRate, recovSens, resetV, resetStep;
  logic spikeValid, sweepDone;
  logic [3:0] spikeIdx;

  int errors = 0;
  int checks = 0;
  int mv [NUM];
  int mu [NUM];
  bit expSpk [NUM];
  int spkCyc [NUM];

  always #4 clk = ~clk;

  spiking_neuron_array #(.W(W), .FRAC(FRAC), .LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .startSweep(startSweep), .curIn(curIn),
    .quadGain(quadGain), .linGain(linGain), .bias(bias), .thresh(thresh),
    .recovRate(recovRate), .recovSens(recovSens), .resetV(resetV), .resetStep(resetStep),
    .spikeValid(spikeValid), .spikeIdx(spikeIdx), .sweepDone(sweepDone)
  );

  function automatic int wr(longint val);
    logic [15:0] b;
    b = val[15:0];
    return int'($signed(b));
  endfunction

  function automatic int fma(int x, int y, int z);
    longint p;
    p = longint'(x) * longint'(y);
    p = p >>> FRAC;
    return wr(longint'(wr(p)) + z);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of one sweep (R3, R4, R8)
  task automatic modelSweep();
    for (int n = 0; n < NUM; n++) begin
      int v, u, cur, p0, p1, vN, q, uN;
      v = mv[n]; u = mu[n];
      cur = int'($signed(curIn[n*W +: W]));
      p0 = fma(int'(quadGain), v, int'(linGain));
      p1 = fma(p0, v, int'(bias));
      vN = wr(longint'(v) + p1 - u + cur);
      q  = fma(int'(recovSens), v, wr(-longint'(u)));
      uN = fma(int'(recovRate), q, u);
      if (vN >= int'(thresh)) begin
        expSpk[n] = 1'b1; mv[n] = int'(resetV); mu[n] = wr(longint'(uN) + resetStep);
      end else begin
        expSpk[n] = 1'b0; mv[n] = vN; mu[n] = uN;
      end
    end
  endtask

  // caller has raised startSweep at a negedge; returns at the negedge of the done cycle
  task automatic runSweep(bit poke);
    int cyc;
    bit seenDone;
    modelSweep();
    for (int n = 0; n < NUM; n++) spkCyc[n] = -1;
    @(posedge clk);
    @(negedge clk);
    startSweep = 1'b0;
    cyc = 0;
    seenDone = 1'b0;
    while (!seenDone && cyc < 400) begin
      if (poke && (cyc == 30 || cyc == 4*NUM+LAT-1)) startSweep = 1'b1;  // R6 mid-sweep starts
      @(posedge clk);
      @(negedge clk);
      startSweep = 1'b0;
      cyc++;
      if (spikeValid) begin
        check(spkCyc[spikeIdx] == -1, "R5 duplicate spike", int'(spikeIdx), -1);
        spkCyc[spikeIdx] = cyc;
      end
      if (sweepDone) seenDone = 1'b1;
    end
    check(cyc == 4*NUM+LAT, "R2 done timing", cyc, 4*NUM+LAT);
    for (int n = 0; n < NUM; n++) begin
      int expC;
      expC = expSpk[n] ? 3*NUM+n+LAT+1 : -1;
      check(spkCyc[n] == expC, $sformatf("R4/R5 neuron %0d spike cycle", n), spkCyc[n], expC);
    end
  endtask

  task automatic setParams(int th);
    quadGain = 16'sd10;  linGain = 16'sd128; bias = 16'sd26;  thresh = 16'(th);
    recovRate = 16'sd26; recovSens = 16'sd64; resetV = -16'sd256; resetStep = 16'sd128;
  endtask

  task automatic setCur(int mode);
    for (int n = 0; n < NUM; n++) begin
      int val;
      case (mode)
        0: val = 0;
        1: val = n * 24;
        2: val = -n * 40;
        3: val = (n % 2) ? 600 : -300;
        4: val = 2000 - n * 250;
        default: val = (n * 7919) % 1500 - 500;
      endcase
      curIn[n*W +: W] = 16'(val);
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    setParams(512);
    setCur(0);
    for (int n = 0; n < NUM; n++) begin mv[n] = 0; mu[n] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: quiet outputs after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!spikeValid && !sweepDone, "R1 outputs idle after reset", int'(spikeValid), 0);
    end
    // chained sweeps, start raised in each done cycle (R7)
    for (int s = 0; s < 12; s++) begin
      setCur(s % 6);
      if (s == 6) setParams(-32768);   // boundary: every neuron fires
      if (s == 7) setParams(32767);
      if (s == 8) setParams(300);
      startSweep = 1'b1;
      runSweep(s == 3 || s == 9);      // R6 pokes
      if (s == 4) repeat (7) @(negedge clk);
    end
    // R6: no spurious sweep afterwards
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (spikeValid || sweepDone)
        check(1'b0, "R6 activity after last sweep", int'(sweepDone), 0);
    end
    check(1'b1, "R6 idle window", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule